// File: doc/BRIEF.md
# SPI Command Frame Receiver

This block is the serial front end of a six-channel half-bridge controller. It takes the raw SPI pins (chip select, serial clock and serial data in), oversamples them in the system clock domain, and shifts a 16-bit command word in least significant bit first. On the same clock edges it shifts a 16-bit status word out. A chip-select window is accepted only if it contains a whole, nonzero number of 16-bit words. When chip select rises on such a window, the last 16 bits received are written to the command register, a one-cycle commit strobe is raised, and a clear-request strobe is raised if bit 0 of that word is set.

The status word is captured when chip select falls. Its bit 0, the thermal-warning flag, therefore appears on the serial output before any clock edge. After 16 bits the serial output passes on the received data delayed by one word, so several controllers can be chained output to input. A low enable input puts the block to sleep. In sleep the stored command is cleared and all SPI activity is ignored. The system clock must run at least four times faster than the serial clock.

Top module: `spi_cmd_rx`

## Requirements
- R1: A 16-bit frame is received least significant bit first, with SI sampled on falling SCLK edges. On the rising edge of CSB the word appears on `cmd_o`, and `commit_o` pulses high for exactly one cycle.
- R2: If the number of falling SCLK edges in a CSB-low window is zero or not a multiple of 16, nothing is committed: `cmd_o` keeps its previous value and `commit_o` stays low.
- R3: In a window of 32 or 48 bits, the last 16 bits received are committed. Bit k of the command is the bit received at position (n-16+k), where n is the bit count.
- R4: While CSB is high, `so_oe_o` is 0 and `so_o` is 0.
- R5: After CSB falls, `so_o` shows bit 0 of `status_i` as sampled at that fall, before any SCLK edge.
- R6: At the k-th falling SCLK edge, `so_o` shows status bit k-1 (k = 1..16). Each bit advances on a rising SCLK edge. A change on `status_i` after CSB falls does not affect the bits shifted out.
- R7: At falling SCLK edge 16+j, `so_o` shows the SI bit that was received at position j (daisy chain, one word of delay).
- R8: `srr_o` pulses together with `commit_o` exactly when bit 0 of the committed word is 1, and at no other time.
- R9: While `en_i` is low, `cmd_o` is cleared to 0, `so_oe_o` is 0, and SPI frames cause no commit.
- R10: After reset `cmd_o` is 0, `so_oe_o` is 0 and `commit_o` and `srr_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, at least 4x SCLK |
| rst_ni | input | 1 | Active-low asynchronous reset |
| en_i | input | 1 | Enable; low selects sleep and clears the command |
| csb_i | input | 1 | SPI chip select, active low |
| sclk_i | input | 1 | SPI serial clock, idle low |
| si_i | input | 1 | SPI serial data in |
| status_i | input | 16 | Status word, captured at CSB fall |
| so_o | output | 1 | Serial data out (0 when not driven) |
| so_oe_o | output | 1 | Serial output enable (pad tristate control) |
| cmd_o | output | 16 | Committed command word |
| commit_o | output | 1 | One-cycle strobe on a valid frame commit |
| srr_o | output | 1 | One-cycle clear request, bit 0 of committed word |

## Verification
The checker watches these properties on every cycle: the command only changes through a commit or through the sleep clear, the clear-request strobe only rises together with a commit whose bit 0 is set, the commit strobe is a single cycle, the output stays quiet while it is not enabled, and a long sleep leaves the command at zero. Other behaviours depend on the SPI bit sequence, and only the bench's scenarios can show them: least-significant-first assembly, the word-multiple validity rule over a sweep of frame lengths, the status snapshot and its bit order, the daisy-chain forwarding and the immediate thermal-warning level. The bench compares each of these against values it computes from the frame contents.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;
  typedef struct packed {
    logic sclk_rise;
    logic sclk_fall;
    logic cs_fall;
    logic cs_rise;
  } spi_ev_t;
endpackage

// File: rtl/spi_cmd_sync.sv
module spi_cmd_sync #(
  parameter int unsigned N = 4,
  parameter int unsigned STAGES = 2,
  parameter logic [N-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] d_i,
  output logic [N-1:0] q_o
);
  for (genvar b = 0; b < N; b++) begin : g_bit
    logic [STAGES-1:0] chain_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q <= {STAGES{RST_VAL[b]}};
      else         chain_q <= {chain_q[STAGES-2:0], d_i[b]};
    end
    assign q_o[b] = chain_q[STAGES-1];
  end
endmodule

// File: rtl/spi_cmd_edge.sv
module spi_cmd_edge
  import spi_cmd_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    en_s_i,
  input  logic    csb_s_i,
  input  logic    sclk_s_i,
  output spi_ev_t ev_o
);
  logic csb_q, sclk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      csb_q  <= 1'b1;
      sclk_q <= 1'b0;
    end else begin
      csb_q  <= csb_s_i;
      sclk_q <= sclk_s_i;
    end
  end

  always_comb begin
    ev_o.cs_fall   = en_s_i & csb_q & ~csb_s_i;
    ev_o.cs_rise   = en_s_i & ~csb_q & csb_s_i;
    ev_o.sclk_rise = en_s_i & ~csb_s_i & ~sclk_q & sclk_s_i;
    ev_o.sclk_fall = en_s_i & ~csb_s_i & sclk_q & ~sclk_s_i;
  end
endmodule

// File: rtl/spi_cmd_shift.sv
module spi_cmd_shift
  import spi_cmd_pkg::*;
#(
  parameter int unsigned WORD_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_s_i,
  input  spi_ev_t           ev_i,
  input  logic              si_s_i,
  input  logic [WORD_W-1:0] status_i,
  output logic              active_o,
  output logic              so_bit_o,
  output logic [WORD_W-1:0] rx_word_o,
  output logic              frame_ok_o
);
  localparam int unsigned CNT_W = (WORD_W > 1) ? $clog2(WORD_W) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(WORD_W - 1);

  logic              active_q, seen_q, last_si_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [WORD_W-1:0] tx_q, rx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q  <= 1'b0;
      seen_q    <= 1'b0;
      last_si_q <= 1'b0;
      cnt_q     <= '0;
      tx_q      <= '0;
      rx_q      <= '0;
    end else if (!en_s_i) begin
      active_q  <= 1'b0;
      seen_q    <= 1'b0;
      last_si_q <= 1'b0;
      cnt_q     <= '0;
      tx_q      <= '0;
      rx_q      <= '0;
    end else if (ev_i.cs_fall) begin
      active_q  <= 1'b1;
      seen_q    <= 1'b0;
      last_si_q <= 1'b0;
      cnt_q     <= '0;
      tx_q      <= status_i;  // coherent snapshot
    end else if (ev_i.cs_rise) begin
      active_q  <= 1'b0;
    end else if (active_q) begin
      if (ev_i.sclk_fall) begin
        rx_q      <= {si_s_i, rx_q[WORD_W-1:1]};
        last_si_q <= si_s_i;
        seen_q    <= 1'b1;
        cnt_q     <= (cnt_q == CNT_LAST) ? '0 : cnt_q + CNT_W'(1);
      end
      // first rising edge keeps bit 0 in place; later ones advance
      if (ev_i.sclk_rise && seen_q) begin
        tx_q <= {last_si_q, tx_q[WORD_W-1:1]};
      end
    end
  end

  assign active_o   = active_q;
  assign so_bit_o   = tx_q[0];
  assign rx_word_o  = rx_q;
  assign frame_ok_o = active_q & seen_q & (cnt_q == '0);
endmodule

// File: rtl/spi_cmd_rx.sv
module spi_cmd_rx
  import spi_cmd_pkg::*;
#(
  parameter int unsigned WORD_W = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              csb_i,
  input  logic              sclk_i,
  input  logic              si_i,
  input  logic [WORD_W-1:0] status_i,
  output logic              so_o,
  output logic              so_oe_o,
  output logic [WORD_W-1:0] cmd_o,
  output logic              commit_o,
  output logic              srr_o
);
  localparam int unsigned N_SYNC = 4;
  localparam logic [N_SYNC-1:0] SYNC_RST = 4'b0100;  // {en, csb, sclk, si}

  logic [N_SYNC-1:0] raw, synced;
  logic en_s, csb_s, sclk_s, si_s;
  spi_ev_t ev;
  logic active, so_bit, frame_ok;
  logic [WORD_W-1:0] rx_word;
  logic [WORD_W-1:0] cmd_q;
  logic commit_q, srr_q;

  assign raw = {en_i, csb_i, sclk_i, si_i};
  assign {en_s, csb_s, sclk_s, si_s} = synced;

  spi_cmd_sync #(
    .N(N_SYNC), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)
  ) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(raw), .q_o(synced)
  );

  spi_cmd_edge u_edge (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_s_i(en_s),
    .csb_s_i(csb_s), .sclk_s_i(sclk_s), .ev_o(ev)
  );

  spi_cmd_shift #(.WORD_W(WORD_W)) u_shift (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_s_i(en_s), .ev_i(ev),
    .si_s_i(si_s), .status_i(status_i), .active_o(active),
    .so_bit_o(so_bit), .rx_word_o(rx_word), .frame_ok_o(frame_ok)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q    <= '0;
      commit_q <= 1'b0;
      srr_q    <= 1'b0;
    end else if (!en_s) begin
      cmd_q    <= '0;
      commit_q <= 1'b0;
      srr_q    <= 1'b0;
    end else begin
      commit_q <= 1'b0;
      srr_q    <= 1'b0;
      if (ev.cs_rise && frame_ok) begin
        cmd_q    <= rx_word;
        commit_q <= 1'b1;
        srr_q    <= rx_word[0];
      end
    end
  end

  assign cmd_o    = cmd_q;
  assign commit_o = commit_q;
  assign srr_o    = srr_q;
  assign so_oe_o  = active;
  assign so_o     = active & so_bit;
endmodule

// File: rtl/spi_cmd_rx_chk.sv
module spi_cmd_rx_chk #(
  parameter int unsigned WORD_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              en_i,
  input logic              csb_i,
  input logic              so_o,
  input logic              so_oe_o,
  input logic [WORD_W-1:0] cmd_o,
  input logic              commit_o,
  input logic              srr_o
);
  // R2: command only moves on a commit or the sleep clear
  assert_cmd_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(cmd_o) |-> (commit_o || cmd_o == '0));

  // R8: clear request only alongside a commit carrying bit 0
  assert_srr_tied_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    srr_o |-> (commit_o && cmd_o[0]));

  assert_srr_when_set_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (commit_o && cmd_o[0]) |-> srr_o);

  // R1: commit strobe lasts one cycle
  assert_commit_pulse_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_o |=> !commit_o);

  // R4: output quiet when not enabled
  assert_so_quiet_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !so_oe_o |-> !so_o);

  // R9: long sleep leaves no command and no output drive
  assert_sleep_clear_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !$past(en_i) && !$past(en_i, 2) && !$past(en_i, 3))
      |-> (cmd_o == '0 && !so_oe_o && !commit_o));
endmodule

bind spi_cmd_rx spi_cmd_rx_chk #(.WORD_W(WORD_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .csb_i(csb_i),
  .so_o(so_o), .so_oe_o(so_oe_o), .cmd_o(cmd_o),
  .commit_o(commit_o), .srr_o(srr_o)
);

// File: tb/spi_cmd_rx_bench.sv
`timescale 1ns/1ps
module spi_cmd_rx_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        en_i = 1'b1;
  logic        csb_i = 1'b1;
  logic        sclk_i = 1'b0;
  logic        si_i = 1'b0;
  logic [15:0] status_i = '0;
  logic        so_o, so_oe_o, commit_o, srr_o;
  logic [15:0] cmd_o;

  int checks = 0;
  int failures = 0;
  int commit_cnt = 0;
  int srr_cnt = 0;
  bit done = 1'b0;

  always #10 clk_i = ~clk_i;  // 50 MHz

  spi_cmd_rx u_spi_cmd_rx (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .csb_i(csb_i),
    .sclk_i(sclk_i), .si_i(si_i), .status_i(status_i), .so_o(so_o),
    .so_oe_o(so_oe_o), .cmd_o(cmd_o), .commit_o(commit_o), .srr_o(srr_o)
  );

  always @(posedge clk_i) begin
    if (rst_ni && commit_o) commit_cnt++;
    if (rst_ni && srr_o) srr_cnt++;
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic run_frame(input int nbits, input logic [63:0] din, input logic [15:0] st,
                           input bit chk_so, input int mid_at, input logic [15:0] st_mid);
    status_i = st;
    csb_i = 1'b0;
    wait_clk(5);
    if (chk_so) begin
      check(so_oe_o == 1'b1, "R4 oe in frame", so_oe_o, 1);
      check(so_o == st[0], "R5 immediate bit0", so_o, st[0]);
    end
    for (int i = 0; i < nbits; i++) begin
      sclk_i = 1'b1;
      si_i = din[i];
      if (i == mid_at) status_i = st_mid;
      wait_clk(4);
      if (chk_so) begin
        if (i < 16) check(so_o == st[i], "R6 status bit", so_o, st[i]);
        else        check(so_o == din[i-16], "R7 chain bit", so_o, din[i-16]);
      end
      sclk_i = 1'b0;
      wait_clk(4);
    end
    csb_i = 1'b1;
    si_i = 1'b0;
    wait_clk(8);
    if (chk_so) check(so_oe_o == 1'b0 && so_o == 1'b0, "R4 idle quiet", {so_oe_o, so_o}, 0);
  endtask

  initial begin
    #(20ns * 200000);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [15:0] exp_cmd;
    int exp_commits, exp_srr;
    wait_clk(3);
    // R10 reset state
    check(cmd_o == 16'h0, "R10 cmd reset", cmd_o, 0);
    check(so_oe_o == 1'b0, "R10 oe reset", so_oe_o, 0);
    check(commit_o == 1'b0 && srr_o == 1'b0, "R10 strobes reset", {commit_o, srr_o}, 0);
    rst_ni = 1'b1;
    wait_clk(6);
    exp_cmd = '0;
    exp_commits = 0;
    exp_srr = 0;

    // R1/R6/R8: single-word sweep
    for (int k = 0; k < 19; k++) begin
      logic [15:0] d, s;
      d = (k < 16) ? (16'h1 << k) : ((k == 16) ? 16'hFFFF : ((k == 17) ? 16'h0000 : 16'hA55A));
      s = ~d ^ 16'(k * 16'h0913);
      run_frame(16, {48'h0, d}, s, 1'b1, -1, 16'h0);
      exp_cmd = d;
      exp_commits++;
      if (d[0]) exp_srr++;
      check(cmd_o == exp_cmd, "R1 cmd value", cmd_o, exp_cmd);
      check(commit_cnt == exp_commits, "R1 commit count", commit_cnt, exp_commits);
      check(srr_cnt == exp_srr, "R8 srr count", srr_cnt, exp_srr);
    end

    // R2/R3/R7: frame length sweep 0..48
    for (int n = 0; n <= 48; n++) begin
      logic [63:0] d;
      d = 64'h0123_4567_89AB_CDEF ^ (64'(n) * 64'h1111_2222_3333_4445);
      run_frame(n, d, 16'h5A3C ^ 16'(n), 1'b1, -1, 16'h0);
      if (n > 0 && n % 16 == 0) begin
        exp_cmd = d[n-16 +: 16];
        exp_commits++;
        if (exp_cmd[0]) exp_srr++;
        check(cmd_o == exp_cmd, "R3 last word committed", cmd_o, exp_cmd);
      end else begin
        check(cmd_o == exp_cmd, "R2 invalid length kept", cmd_o, exp_cmd);
      end
      check(commit_cnt == exp_commits, "R2 commit count", commit_cnt, exp_commits);
      check(srr_cnt == exp_srr, "R8 srr count", srr_cnt, exp_srr);
    end

    // R6: status change mid-frame must not leak
    run_frame(16, 64'h0000_0000_0000_3C3C, 16'h8421, 1'b1, 5, 16'h7BDE);
    exp_cmd = 16'h3C3C;
    exp_commits++;
    check(cmd_o == exp_cmd, "R6 snapshot frame commit", cmd_o, exp_cmd);

    // R9: sleep clears and ignores SPI
    en_i = 1'b0;
    wait_clk(8);
    check(cmd_o == 16'h0, "R9 sleep clears cmd", cmd_o, 0);
    csb_i = 1'b0;
    wait_clk(6);
    check(so_oe_o == 1'b0, "R9 no drive in sleep", so_oe_o, 0);
    csb_i = 1'b1;
    wait_clk(4);
    run_frame(16, 64'h0000_0000_0000_F00F, 16'h1, 1'b0, -1, 16'h0);
    check(cmd_o == 16'h0, "R9 frame ignored in sleep", cmd_o, 0);
    check(commit_cnt == exp_commits, "R9 no commit in sleep", commit_cnt, exp_commits);
    en_i = 1'b1;
    wait_clk(6);
    run_frame(16, 64'h0000_0000_0000_00C1, 16'h0001, 1'b1, -1, 16'h0);
    exp_commits++;
    exp_srr++;
    check(cmd_o == 16'h00C1, "R1 commit after wake", cmd_o, 16'h00C1);
    check(srr_cnt == exp_srr, "R8 srr after wake", srr_cnt, exp_srr);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule